// File: doc/BRIEF.md
# Burst Write Bridge for a Multiplexed-Control Processor Bus

This block is a synchronous slave that connects an asynchronous processor bus to an on-chip register array. The bus has separate read and write strobes, an address latch strobe and an active-low chip select. The block samples every bus pin with a fast system clock and turns each completed write cycle into a one-cycle write strobe, carrying an offset and a data word, into a 512-entry register file.

A burst opens when the address latch strobe falls while the chip is selected. The offset on the address bus at that moment becomes the target of the first write. Every later write strobe in the same burst goes to the next offset, with no new address phase, and the offset wraps from the top of the space back to zero. The burst closes when chip select is released or when the latch strobe rises again. A new latch pulse starts a fresh burst at the new address.

All bus inputs pass through a two-stage synchronizer, so each strobe level must be held for at least three system clocks. Read cycles are not served, and the data bus is treated as an input only.

Top module: `burst_wr_bridge`

## Requirements
- R1: While reset is asserted, and right after it, `reg_we_o` is 0 and `reg_addr_o` and `reg_data_o` are all zeros.
- R2: A falling edge of `ale_i` while `cs_n_i` is low captures `addr_i` as the start offset, and the first write of the burst goes to that offset.
- R3: Each further write in the same burst targets the previous target plus one. The offset register steps in the cycle after the write pulse.
- R4: The offset wraps from 0x1FF to 0x000 within a burst.
- R5: A write strobe while `cs_n_i` is high produces no write.
- R6: Releasing `cs_n_i` closes the burst. Write strobes after chip select returns, with no new latch pulse, produce no write.
- R7: A new `ale_i` pulse during a burst starts a new burst at the newly latched address.
- R8: A write strobe while `rd_n_i` is low produces no write and does not advance the offset.
- R9: Each accepted write is a `reg_we_o` pulse exactly one cycle wide. It is issued on the rising edge of `wr_n_i` (low to high) and carries the data present on `data_i` at that edge.
- R10: After reset, no write is issued until a burst has been opened by a latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch strobe, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low; a write completes on its rising edge |
| addr_i | input | 9 | Start offset, sampled when the latch strobe falls |
| data_i | input | 16 | Write data |
| reg_we_o | output | 1 | One-cycle write enable into the register array |
| reg_addr_o | output | 9 | Offset of the current write |
| reg_data_o | output | 16 | Data of the current write |

## Verification
A wrong offset register shows up at the very next write pulse as a wrong address on `reg_addr_o`. It also shows up in every later write of that burst, so bursts of several writes that cross the top of the address space expose a missed step or a missed wrap at once. A wrong burst-active flag shows up as an extra or missing write pulse. This is checked by counting pulses after strobes given with chip select released, with the read strobe low, or with no latch pulse. A stuck enable register shows up as a pulse wider than one cycle.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned SYNC_STAGES = 2;
  // Order of the control bits inside the synchronized control vector.
  localparam int unsigned CTL_ALE = 0;
  localparam int unsigned CTL_CSN = 1;
  localparam int unsigned CTL_RDN = 2;
  localparam int unsigned CTL_WRN = 3;
  localparam int unsigned CTL_W   = 4;
  // Idle levels of the control inputs: latch low, all active-low pins high.
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1110;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_word_t;
endpackage

// File: rtl/bwb_rst_sync.sv
module bwb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bwb_sync.sv
module bwb_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bwb_edge.sv
module bwb_edge #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise_o[b] = lvl_i[b] & ~prev_q[b];
      assign fall_o[b] = ~lvl_i[b] & prev_q[b];
    end
  endgenerate
endmodule

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_lvl,
  input  logic              ale_rise,
  input  logic              ale_fall,
  input  logic              cs_n_lvl,
  input  logic              rd_n_lvl,
  input  logic              wr_done,
  input  bus_word_t         bus,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              active_q, active_d;
  logic [ADDR_W-1:0] offset_q, offset_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              open_burst;

  assign open_burst = ale_fall & ~cs_n_lvl;

  always_comb begin
    active_d = active_q;
    if (cs_n_lvl || ale_rise) active_d = 1'b0;
    else if (ale_fall)        active_d = 1'b1;

    we_d = active_q & ~cs_n_lvl & ~ale_lvl & rd_n_lvl & wr_done & ~ale_fall;

    offset_d = offset_q;
    if (open_burst) offset_d = bus.addr;
    else if (we_q)  offset_d = offset_q + 1'b1;

    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (we_d) begin
      waddr_d = offset_q;
      wdata_d = bus.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      offset_q <= '0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      active_q <= active_d;
      offset_q <= offset_d;
      we_q     <= we_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
    end
  end

  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!we_q && waddr_q == '0 && wdata_q == '0));

  assert_open_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    open_burst |=> (offset_q == $past(bus.addr)));

  assert_offset_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && !open_burst) |=> (offset_q == $past(waddr_q) + 1'b1));

  assert_no_write_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_lvl |=> !we_q);

  assert_read_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_lvl |=> !we_q);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !we_q);
endmodule

// File: rtl/burst_wr_bridge.sv
module burst_wr_bridge
  import bwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o
);
  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  logic             rst_sync_n;
  logic [CTL_W-1:0] ctl_raw, ctl_s, ctl_rise, ctl_fall;
  logic [BUS_W-1:0] bus_s;
  bus_word_t        bus_w;

  assign ctl_raw[CTL_ALE] = ale_i;
  assign ctl_raw[CTL_CSN] = cs_n_i;
  assign ctl_raw[CTL_RDN] = rd_n_i;
  assign ctl_raw[CTL_WRN] = wr_n_i;

  bwb_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bwb_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) i_sync_ctl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  bwb_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_bus (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({addr_i, data_i}),
    .q_o   (bus_s)
  );

  assign bus_w = bus_word_t'(bus_s);

  bwb_edge #(.WIDTH(CTL_W), .RST_VAL(CTL_IDLE)) i_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (ctl_s),
    .rise_o (ctl_rise),
    .fall_o (ctl_fall)
  );

  bwb_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ale_lvl  (ctl_s[CTL_ALE]),
    .ale_rise (ctl_rise[CTL_ALE]),
    .ale_fall (ctl_fall[CTL_ALE]),
    .cs_n_lvl (ctl_s[CTL_CSN]),
    .rd_n_lvl (ctl_s[CTL_RDN]),
    .wr_done  (ctl_rise[CTL_WRN]),
    .bus      (bus_w),
    .we_o     (reg_we_o),
    .waddr_o  (reg_addr_o),
    .wdata_o  (reg_data_o)
  );
endmodule

// File: tb/test_burst_wr_bridge.sv
`timescale 1ns/1ps
module test_burst_wr_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale_i = 1'b0, cs_n_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1;
  logic [8:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic        reg_we_o;
  logic [8:0]  reg_addr_o;
  logic [15:0] reg_data_o;

  int unsigned n_tests = 0, n_fail = 0;
  logic [8:0]  seen_a [256];
  logic [15:0] seen_d [256];
  logic [8:0]  exp_a  [256];
  logic [15:0] exp_d  [256];
  int unsigned n_seen = 0, n_exp = 0, run_len = 0;
  logic [8:0]  model_off = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  burst_wr_bridge i_burst_wr_bridge (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .wr_n_i(wr_n_i), .addr_i(addr_i), .data_i(data_i), .reg_we_o(reg_we_o),
    .reg_addr_o(reg_addr_o), .reg_data_o(reg_data_o)
  );

  // Port monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (reg_we_o) begin
      if (n_seen < 256) begin
        seen_a[n_seen] = reg_addr_o;
        seen_d[n_seen] = reg_data_o;
      end
      n_seen++;
      run_len++;
      if (run_len == 2) begin
        n_tests++; n_fail++;
        $display("FAIL R9 write pulse width actual=%0d expected=1", run_len);
      end
    end else begin
      run_len = 0;
    end
  end

  function automatic logic [8:0] next_off(input logic [8:0] a);
    return a + 9'd1;
  endfunction

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    clks(10);
    n_seen = 0; n_exp = 0;
  endtask

  task automatic latch(input logic [8:0] a);
    cs_n_i = 1'b0; addr_i = a; ale_i = 1'b1; clks(4);
    ale_i = 1'b0; clks(4);
    model_off = a;
  endtask

  // expect_it: 1 if the write should be accepted by the model
  task automatic wr_cycle(input logic [15:0] d, input bit rd_low, input bit expect_it);
    rd_n_i = ~rd_low; data_i = d; wr_n_i = 1'b0; clks(4);
    wr_n_i = 1'b1; clks(4);
    rd_n_i = 1'b1;
    if (expect_it) begin
      exp_a[n_exp] = model_off; exp_d[n_exp] = d; n_exp++;
      model_off = next_off(model_off);
    end
  endtask

  task automatic compare(input string req);
    clks(10);
    check({req, " write count"}, n_seen == n_exp, n_seen, n_exp);
    for (int i = 0; i < n_exp && i < n_seen; i++) begin
      check({req, " offset"}, seen_a[i] == exp_a[i], seen_a[i], exp_a[i]);
      check({req, " data"}, seen_d[i] == exp_d[i], seen_d[i], exp_d[i]);
    end
    n_seen = 0; n_exp = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    #1;
    // R1: outputs idle during reset
    check("R1 we in reset", reg_we_o == 1'b0, reg_we_o, 0);
    clks(3);
    rst_n = 1'b1;
    clks(4);
    check("R1 we after reset", reg_we_o == 1'b0, reg_we_o, 0);
    check("R1 addr after reset", reg_addr_o == 9'h0, reg_addr_o, 0);
    check("R1 data after reset", reg_data_o == 16'h0, reg_data_o, 0);

    // R10: selected but no latch pulse yet
    cs_n_i = 1'b0; clks(2);
    wr_cycle(16'hDEAD, 1'b0, 1'b0);
    compare("R10");

    // R2 R3 R9: plain burst
    latch(9'h005);
    wr_cycle(16'h1111, 1'b0, 1'b1);
    wr_cycle(16'h2222, 1'b0, 1'b1);
    wr_cycle(16'h3333, 1'b0, 1'b1);
    wr_cycle(16'h4444, 1'b0, 1'b1);
    compare("R2 R3 R9");

    // R4: wrap across the top
    latch(9'h1FE);
    for (int i = 0; i < 4; i++) wr_cycle(16'hA000 + 16'(i), 1'b0, 1'b1);
    compare("R4");

    // R5: strobes while deselected; R6: reselect without a latch
    latch(9'h040);
    wr_cycle(16'h0040, 1'b0, 1'b1);
    compare("R5 pre");
    cs_n_i = 1'b1; clks(4);
    wr_cycle(16'hBAD0, 1'b0, 1'b0);
    compare("R5");
    cs_n_i = 1'b0; clks(4);
    wr_cycle(16'hBAD1, 1'b0, 1'b0);
    wr_cycle(16'hBAD2, 1'b0, 1'b0);
    compare("R6");

    // R8: read strobe low blocks the write and keeps the offset
    latch(9'h0A0);
    wr_cycle(16'h5555, 1'b0, 1'b1);
    wr_cycle(16'hBAD3, 1'b1, 1'b0);
    wr_cycle(16'h6666, 1'b0, 1'b1);
    compare("R8");

    // R7: new latch mid-burst
    latch(9'h010);
    wr_cycle(16'h7001, 1'b0, 1'b1);
    wr_cycle(16'h7002, 1'b0, 1'b1);
    latch(9'h100);
    wr_cycle(16'h7003, 1'b0, 1'b1);
    wr_cycle(16'h7004, 1'b0, 1'b1);
    compare("R7");

    // Random bursts (R2 R3 R4 R9)
    for (int b = 0; b < 20; b++) begin
      int len;
      latch(9'($urandom));
      len = 1 + int'($urandom % 6);
      for (int k = 0; k < len; k++) wr_cycle(16'($urandom), 1'b0, 1'b1);
      if ($urandom % 2 == 0) begin
        cs_n_i = 1'b1; clks(4);
      end
      compare("R3 random");
    end
    cs_n_i = 1'b1;
    clear_log();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule